// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose I/O pins that software reaches through a simple word-addressed register bus. Each pin can be driven as an output or read as an input. Every pin input first passes through a two-flop synchroniser. Each pin also has its own interrupt detector. The detector watches for a level or an edge of a chosen polarity. It can latch a status bit, and it can raise a per-pin interrupt. Each pin has a routing code that decides whether its interrupt reaches the application processor.

Two separate enables control what a detected trigger does. One lets the trigger set the status bit. The other lets it assert the interrupt. Either enable works without the other, so an interrupt can fire while the status bit stays clear.

The bank has no hardware dual-edge mode. Software catches both edges by flipping the polarity after each edge, so a polarity change on its own never counts as an edge. A summary output combines all active per-pin interrupts into one line.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every pin register reads 0 and every routing register reads 7. `pin_oe`, `pin_irq` and `summary_irq` are all 0.
- R2: Bit 9 of pin n's config word (address 0x1000+0x10*n) drives `pin_oe[n]`. Bit 1 of its data word (0x1004+0x10*n) drives `pin_out[n]`. Both read back at the same positions.
- R3: Bit 0 of the data word reads the pin input after the two-flop synchroniser. A change driven on `pin_in` is visible on a read after the second rising clock edge, not after the first.
- R4: Pin n's interrupt config word (0x1008+0x10*n) holds four bits: 0 interrupt enable, 1 polarity, 2 detect mode, 3 status enable. Exactly those four bits read back, and all other bits read 0.
- R5: In edge mode (bit 2 = 1), polarity 1 detects a rising edge and polarity 0 a falling edge. With status enable set, a matching edge sets bit 0 of the status word (0x100C+0x10*n) on the third rising clock edge after the pin changes. An edge of the other direction does not set it.
- R6: In level mode (bit 2 = 0), status is set while the synchronised level equals the polarity bit, and it is set again after each clear while that level lasts. The pin interrupt follows the level.
- R7: The status enable and the interrupt enable act independently. With status enable at 0, a trigger leaves status at 0 but can still raise the interrupt. With interrupt enable at 0, status is set but no interrupt is raised.
- R8: Pin n's routing word sits at 0x0400+0x4*n, bits 2:0. `pin_irq[n]` can be 1 only while the code is 4, and any other code holds it at 0 without losing a pending edge interrupt.
- R9: Writing 1 to status bit 0 clears the status bit and the pending edge interrupt. Writing 0 has no effect. A trigger in the same cycle as the clear wins.
- R10: Changing the polarity bit while the input is steady does not produce an edge.
- R11: `summary_irq` is 1 exactly when at least one `pin_irq` bit is 1.
- R12: An edge interrupt stays asserted after the input settles and until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | ADDR_W | Byte address of the word accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, available in the same cycle |
| pin_in | input | N | Pin input levels (asynchronous) |
| pin_out | output | N | Output values of the pins |
| pin_oe | output | N | Output enables of the pins |
| pin_irq | output | N | Per-pin interrupts routed to the application processor |
| summary_irq | output | 1 | OR of all per-pin interrupts |

## Verification
The detector is tested with rising and falling steps under both polarities. This separates correct edge selection from a detector that reacts to any change. Held levels are tested against repeated acknowledges, which shows whether the level mode sets status again and whether a trigger beats a clear in the same cycle. The polarity bit is flipped over a steady input to expose any false edge. The two enables and several routing codes are tried one at a time, so that each gate is seen acting alone. Random register writes with readback check the field positions and the output drive against a shadow copy held in the bench.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // routing codes
    localparam logic [2:0] ROUTE_APP  = 3'd4;
    localparam logic [2:0] ROUTE_NONE = 3'd7;

    // field positions
    localparam int CFG_OE_BIT   = 9;
    localparam int DATA_IN_BIT  = 0;
    localparam int DATA_OUT_BIT = 1;
    localparam int STAT_BIT     = 0;

    // word select inside a pin's 16-byte slot
    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_DATA = 2'd1,
        REG_ICFG = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       oe;
        logic       out;
        logic       rse;       // status enable
        logic       edge_mode;
        logic       pol;
        logic       ie;        // interrupt enable
        logic       status;
        logic       pend;      // latched edge interrupt
        logic       prev;      // previous synchronised level
        logic [2:0] route;
    } pin_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            sync_d[k] = sync_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       s_in,
    input  logic       wr_cfg,
    input  logic       wr_data,
    input  logic       wr_icfg,
    input  logic       wr_ack,
    input  logic       wr_route,
    input  logic [3:0] wlow,
    input  logic       woe,
    output logic       oe,
    output logic       out,
    output logic [3:0] icfg,
    output logic       status,
    output logic [2:0] route,
    output logic       irq
);

    localparam pin_state_t PIN_RESET = '{route: ROUTE_NONE, default: 1'b0};

    pin_state_t st_d, st_q;
    logic edge_hit, level_hit, trig;

    always_comb begin
        st_d      = st_q;
        edge_hit  = st_q.pol ? (s_in & ~st_q.prev) : (~s_in & st_q.prev);
        level_hit = (s_in == st_q.pol);
        trig      = st_q.edge_mode ? edge_hit : level_hit;

        if (wr_cfg)   st_d.oe  = woe;
        if (wr_data)  st_d.out = wlow[DATA_OUT_BIT];
        if (wr_icfg)  {st_d.rse, st_d.edge_mode, st_d.pol, st_d.ie} = wlow;
        if (wr_route) st_d.route = wlow[2:0];

        st_d.prev = s_in;

        // acknowledge first, then a trigger in the same cycle wins
        if (wr_ack && wlow[STAT_BIT]) begin
            st_d.status = 1'b0;
            st_d.pend   = 1'b0;
        end
        if (!st_q.edge_mode || !st_q.ie) st_d.pend = 1'b0;
        if (trig && st_q.rse) st_d.status = 1'b1;
        if (st_q.edge_mode && st_q.ie && edge_hit) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_RESET;
        else        st_q <= st_d;
    end

    assign oe     = st_q.oe;
    assign out    = st_q.out;
    assign icfg   = {st_q.rse, st_q.edge_mode, st_q.pol, st_q.ie};
    assign status = st_q.status;
    assign route  = st_q.route;
    assign irq    = st_q.ie && (st_q.route == ROUTE_APP) &&
                    (st_q.edge_mode ? st_q.pend : level_hit);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int N           = 16,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic [N-1:0]      pin_irq,
    output logic              summary_irq
);

    localparam int              IDX_W      = (N > 1) ? $clog2(N) : 1;
    localparam logic [ADDR_W-1:0] BANK_BASE  = ADDR_W'(16'h1000);
    localparam logic [ADDR_W-1:0] BANK_SPAN  = ADDR_W'(N * 16);
    localparam logic [ADDR_W-1:0] ROUTE_BASE = ADDR_W'(16'h0400);
    localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(N * 4);

    logic [ADDR_W-1:0] bank_off, route_off;
    logic              bank_hit, route_hit;
    logic [IDX_W-1:0]  bank_idx, route_idx;
    reg_sel_e          bank_sel;

    logic [N-1:0] wr_cfg_v, wr_data_v, wr_icfg_v, wr_ack_v, wr_route_v;
    logic [N-1:0] sync_v, stat_vec, ie_vec, rse_vec, routed_vec;
    logic [3:0]   icfg_a  [N];
    logic [2:0]   route_a [N];

    logic unused_wbits;
    assign unused_wbits = ^{wdata[DATA_W-1:CFG_OE_BIT+1], wdata[CFG_OE_BIT-1:4]};

    gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_v)
    );

    // address decode
    always_comb begin
        bank_off  = addr - BANK_BASE;
        route_off = addr - ROUTE_BASE;
        bank_hit  = (addr >= BANK_BASE) && (bank_off < BANK_SPAN) && (addr[1:0] == 2'b00);
        route_hit = (addr >= ROUTE_BASE) && (route_off < ROUTE_SPAN) && (addr[1:0] == 2'b00);
        bank_idx  = bank_off[4 +: IDX_W];
        route_idx = route_off[2 +: IDX_W];
        bank_sel  = reg_sel_e'(bank_off[3:2]);
        for (int i = 0; i < N; i++) begin
            wr_cfg_v[i]   = wr_en && bank_hit && (bank_idx == IDX_W'(i)) && (bank_sel == REG_CFG);
            wr_data_v[i]  = wr_en && bank_hit && (bank_idx == IDX_W'(i)) && (bank_sel == REG_DATA);
            wr_icfg_v[i]  = wr_en && bank_hit && (bank_idx == IDX_W'(i)) && (bank_sel == REG_ICFG);
            wr_ack_v[i]   = wr_en && bank_hit && (bank_idx == IDX_W'(i)) && (bank_sel == REG_STAT);
            wr_route_v[i] = wr_en && route_hit && (route_idx == IDX_W'(i));
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        gpio_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_in    (sync_v[g]),
            .wr_cfg  (wr_cfg_v[g]),
            .wr_data (wr_data_v[g]),
            .wr_icfg (wr_icfg_v[g]),
            .wr_ack  (wr_ack_v[g]),
            .wr_route(wr_route_v[g]),
            .wlow    (wdata[3:0]),
            .woe     (wdata[CFG_OE_BIT]),
            .oe      (pin_oe[g]),
            .out     (pin_out[g]),
            .icfg    (icfg_a[g]),
            .status  (stat_vec[g]),
            .route   (route_a[g]),
            .irq     (pin_irq[g])
        );
        assign ie_vec[g]     = icfg_a[g][0];
        assign rse_vec[g]    = icfg_a[g][3];
        assign routed_vec[g] = (route_a[g] == ROUTE_APP);
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (bank_hit) begin
            unique case (bank_sel)
                REG_CFG:  rdata[CFG_OE_BIT] = pin_oe[bank_idx];
                REG_DATA: begin
                    rdata[DATA_IN_BIT]  = sync_v[bank_idx];
                    rdata[DATA_OUT_BIT] = pin_out[bank_idx];
                end
                REG_ICFG: rdata[3:0]       = icfg_a[bank_idx];
                REG_STAT: rdata[STAT_BIT]  = stat_vec[bank_idx];
                default:  rdata = '0;
            endcase
        end else if (route_hit) begin
            rdata[2:0] = route_a[route_idx];
        end
    end

    assign summary_irq = |pin_irq;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [N-1:0] pin_oe,
    input logic [N-1:0] pin_out,
    input logic [N-1:0] pin_irq,
    input logic [N-1:0] stat_vec,
    input logic [N-1:0] rse_vec,
    input logic [N-1:0] ie_vec,
    input logic [N-1:0] routed_vec
);

    // R7 R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_irq & ~(ie_vec & routed_vec)) == '0);

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

    // R7
    rse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec & ~$past(stat_vec) & ~$past(rse_vec)) == '0);

    // R2
    drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_oe) && $stable(pin_out)));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_irq   (pin_irq),
    .stat_vec  (stat_vec),
    .rse_vec   (rse_vec),
    .ie_vec    (ie_vec),
    .routed_vec(routed_vec)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_irq;
    logic          summary_irq;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic       sh_oe  [NP];
    logic       sh_out [NP];
    logic [3:0] sh_icfg[NP];
    logic [2:0] sh_route[NP];

    gpio_irq_bank #(.N(NP)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_irq(pin_irq), .summary_irq(summary_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] a_reg(int p, int k);
        return 16'h1000 + 16'(p * 16 + k * 4);
    endfunction

    function automatic logic [15:0] a_route(int p);
        return 16'h0400 + 16'(p * 4);
    endfunction

    function automatic logic [31:0] exp_read(int p, int k);
        case (k)
            0: return {22'd0, sh_oe[p], 9'd0};
            1: return {30'd0, sh_out[p], 1'b0};
            2: return {28'd0, sh_icfg[p]};
            default: return {29'd0, sh_route[p]};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; pin_in = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'd1234));
        do_reset();

        // R1 reset state
        foreach (sh_oe[p]) begin
            sh_oe[p] = 0; sh_out[p] = 0; sh_icfg[p] = 0; sh_route[p] = 3'd7;
        end
        for (int p = 0; p < NP; p += NP - 1) begin
            for (int k = 0; k < 4; k++) begin
                rd(a_reg(p, k), v); chk("R1 pin reg", v, 0);
            end
            rd(a_route(p), v); chk("R1 route", v, 7);
        end
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(pin_irq), 0);
        chk("R1 summary", 32'(summary_irq), 0);

        // R2 output drive
        wr(a_reg(2, 0), 32'h200);
        wr(a_reg(2, 1), 32'h2);
        chk("R2 oe", 32'(pin_oe[2]), 1);
        chk("R2 out", 32'(pin_out[2]), 1);
        rd(a_reg(2, 0), v); chk("R2 cfg read", v, 32'h200);
        rd(a_reg(2, 1), v); chk("R2 data read", v, 32'h2);

        // R3 synchroniser latency
        step(1);
        pin_in[5] = 1'b1;
        step(1); rd(a_reg(5, 1), v); chk("R3 after one edge", v, 0);
        step(1); rd(a_reg(5, 1), v); chk("R3 after two edges", v, 1);

        // R4 interrupt config fields
        wr(a_reg(1, 2), 32'hB);
        rd(a_reg(1, 2), v); chk("R4 icfg read", v, 32'hB);
        wr(a_reg(1, 2), 32'hFFFF_FFFF);
        rd(a_reg(1, 2), v); chk("R4 icfg masked", v, 32'hF);

        do_reset();

        // R5 rising edge, rse+edge+pol+ie = 0xF
        wr(a_route(0), 4);
        wr(a_reg(0, 2), 32'hF);
        pin_in[0] = 1'b1;
        step(2); rd(a_reg(0, 3), v); chk("R5 status before third edge", v, 0);
        step(1); rd(a_reg(0, 3), v); chk("R5 status rising", v, 1);
        chk("R5 irq rising", 32'(pin_irq[0]), 1);
        chk("R11 summary one pin", 32'(summary_irq), 1);
        // R12 holds after input settles
        step(5);
        chk("R12 irq held", 32'(pin_irq[0]), 1);
        // R9 write 0 has no effect
        wr(a_reg(0, 3), 0);
        rd(a_reg(0, 3), v); chk("R9 write zero", v, 1);
        // R9 ack
        wr(a_reg(0, 3), 1);
        rd(a_reg(0, 3), v); chk("R9 ack status", v, 0);
        chk("R9 ack irq", 32'(pin_irq[0]), 0);
        chk("R11 summary none", 32'(summary_irq), 0);
        // R5 falling edge ignored with pol=1
        pin_in[0] = 1'b0;
        step(4); rd(a_reg(0, 3), v); chk("R5 wrong direction", v, 0);
        // R10 pol flip on steady low
        wr(a_reg(0, 2), 32'hD);
        step(4); rd(a_reg(0, 3), v); chk("R10 flip low", v, 0);
        chk("R10 flip low irq", 32'(pin_irq[0]), 0);
        // R5 falling edge with pol=0
        pin_in[0] = 1'b1;
        step(4); rd(a_reg(0, 3), v); chk("R5 rising with pol0", v, 0);
        pin_in[0] = 1'b0;
        step(3); rd(a_reg(0, 3), v); chk("R5 status falling", v, 1);
        wr(a_reg(0, 3), 1);
        // R10 flip on steady high
        pin_in[0] = 1'b1;
        step(4); wr(a_reg(0, 3), 1);
        wr(a_reg(0, 2), 32'hF);
        wr(a_reg(0, 2), 32'hD);
        step(4); rd(a_reg(0, 3), v); chk("R10 flip high", v, 0);

        // R6 level high, rse+pol+ie = 0xB
        wr(a_route(1), 4);
        wr(a_reg(1, 2), 32'hB);
        step(3); rd(a_reg(1, 3), v); chk("R6 level inactive", v, 0);
        chk("R6 irq inactive", 32'(pin_irq[1]), 0);
        pin_in[1] = 1'b1;
        step(3); rd(a_reg(1, 3), v); chk("R6 level status", v, 1);
        chk("R6 level irq", 32'(pin_irq[1]), 1);
        wr(a_reg(1, 3), 1);
        rd(a_reg(1, 3), v); chk("R9 set wins over ack", v, 1);
        step(2); wr(a_reg(1, 3), 1);
        rd(a_reg(1, 3), v); chk("R6 re-set while held", v, 1);
        pin_in[1] = 1'b0;
        step(3); chk("R6 irq follows level", 32'(pin_irq[1]), 0);
        wr(a_reg(1, 3), 1);
        rd(a_reg(1, 3), v); chk("R6 clear after release", v, 0);

        // R7 rse=0, ie=1: edge+pol+ie = 0x7
        wr(a_route(2), 4);
        wr(a_reg(2, 2), 32'h7);
        pin_in[2] = 1'b1;
        step(3); rd(a_reg(2, 3), v); chk("R7 status gated", v, 0);
        chk("R7 irq fires", 32'(pin_irq[2]), 1);
        // R7 ie=0, rse=1: 0xE
        wr(a_route(3), 4);
        wr(a_reg(3, 2), 32'hE);
        pin_in[3] = 1'b1;
        step(3); rd(a_reg(3, 3), v); chk("R7 status set", v, 1);
        chk("R7 irq gated", 32'(pin_irq[3]), 0);

        // R8 routing codes
        wr(a_route(2), 7);
        chk("R8 route none", 32'(pin_irq[2]), 0);
        wr(a_route(2), 4);
        chk("R8 route app keeps pending", 32'(pin_irq[2]), 1);
        wr(a_route(2), 5);
        chk("R8 route other", 32'(pin_irq[2]), 0);
        rd(a_route(2), v); chk("R8 route read", v, 5);

        // R11 two sources
        wr(a_route(2), 4);
        wr(a_reg(0, 2), 32'hF);
        pin_in[0] = 1'b0;
        step(1); pin_in[0] = 1'b1;
        step(4);
        chk("R11 two pins", 32'(pin_irq[2:0]), 32'h5);
        wr(a_reg(2, 3), 1);
        chk("R11 summary after one ack", 32'(summary_irq), 1);
        wr(a_reg(0, 3), 1);
        chk("R11 summary all acked", 32'(summary_irq), 0);

        // random register writes with readback (R2 R4 R8)
        do_reset();
        for (int it = 0; it < 150; it++) begin
            int p, k;
            logic [31:0] d;
            p = int'($urandom % NP);
            k = int'($urandom % 4);
            d = $urandom;
            if (k == 3) wr(a_route(p), d); else wr(a_reg(p, k), d);
            case (k)
                0: sh_oe[p]    = d[9];
                1: sh_out[p]   = d[1];
                2: sh_icfg[p]  = d[3:0];
                default: sh_route[p] = d[2:0];
            endcase
            if (k == 3) rd(a_route(p), v); else rd(a_reg(p, k), v);
            chk("R4 R8 random readback", v, exp_read(p, k));
            chk("R2 random drive", {30'd0, pin_oe[p], pin_out[p]}, {30'd0, sh_oe[p], sh_out[p]});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule